// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a bank of digital input lines and raises one interrupt request when a programmed change-of-state condition is met. Every input passes through a two-flop synchroniser. Edges and levels are judged on the synchronised samples. Only the lowest sixteen channels can take part in the interrupt decision.

The block has two trigger modes. In edge mode, the interrupt fires as soon as any enabled channel shows the edge chosen for it. In level mode, the interrupt fires when every enabled channel sits at its chosen level in the same cycle. After a level-mode trigger the logic stays blocked until a selected input changes level.

A small synchronous register port holds the control word and two channel masks, and gives access to a status word. Reading the status word clears it. The interrupt line stays high while any status bit is set.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Each input passes through two synchronising flops; a change on an input can set status no earlier than the third rising clock edge after it is applied, and irq is high after that edge.
- R2: Only din[15:0] take part in the interrupt decision. din[31:16] never set status or irq. The mask registers hold 16 bits and read bits 31:16 as zero.
- R3: The control register is at address 0. Bit 2 is the enable and bit 1 is the mode (0 = edge, 1 = level); all other bits read as zero. While the enable is 0, no status bit is set.
- R4: Edge mode: a channel set in the high mask (address 1) triggers on a rising edge, and a channel set in the low mask (address 2) triggers on a falling edge. The status bit of each triggering channel is set.
- R5: Level mode: the trigger happens when every channel in either mask is at its selected level (high for the high mask, low for the low mask). All selected channels are then set in status.
- R6: After a level-mode trigger, no new trigger happens until a selected channel changes level. Changes on unselected channels do not re-arm the logic. Any register write re-arms it.
- R7: The status register is at address 3. A read with rd_stb high returns its value and clears it at that clock edge; a trigger in the same cycle still sets its bits.
- R8: irq is high exactly while the status register is nonzero.
- R9: With both masks zero, irq is never raised, in either mode.
- R10: Reset clears all registers and drives irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 32 | Asynchronous digital inputs |
| addr | input | 2 | Register select for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_stb | input | 1 | One-cycle read strobe; clears status when addr is 3 |
| rd_data | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- Status is left alone while the block is disabled.
- A status read with no trigger in that cycle empties the register.
- A rise of irq always follows a trigger.
- Empty masks produce no trigger.
- Edge pulses last one cycle.
- Level mode never triggers on two cycles in a row.

The bench scenarios cover what these properties cannot:
- The exact three-edge latency.
- The correct status pattern for each mix of masks and input changes.
- Ignoring of the upper channels.
- Re-arming in level mode, which needs a change away from the condition and back, while a toggle on an unselected channel does not re-arm.

// File: rtl/cos_pkg.sv
package cos_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_HIGH = 2'd1,
        REG_LOW  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT   = 2;
    localparam int CTRL_MODE_BIT = 1;

    typedef struct packed {
        logic en;
        logic level_mode;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [31:0] w);
        ctrl_t c;
        c.en         = w[CTRL_EN_BIT];
        c.level_mode = w[CTRL_MODE_BIT];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_encode(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[CTRL_EN_BIT]   = c.en;
        w[CTRL_MODE_BIT] = c.level_mode;
        return w;
    endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            cur_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= d_async;
            cur_o  <= meta_q;
            prev_o <= cur_o;
        end
    end
endmodule

// File: rtl/cos_trigger.sv
module cos_trigger #(
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          level_mode,
    input  logic          rearm,
    input  logic [CH-1:0] m_high,
    input  logic [CH-1:0] m_low,
    input  logic [CH-1:0] cur,
    input  logic [CH-1:0] prev,
    output logic [CH-1:0] hit_vec
);
    logic [CH-1:0] rise, fall, sel, edge_hits, met;
    logic          all_met, sel_change, fire_lvl, armed_q;

    always_comb begin
        rise       = cur & ~prev;
        fall       = ~cur & prev;
        sel        = m_high | m_low;
        edge_hits  = (rise & m_high) | (fall & m_low);
        met        = (cur & m_high) | (~cur & m_low);
        all_met    = (|sel) && ((met & sel) == sel);
        sel_change = |((rise | fall) & sel);
        fire_lvl   = en && level_mode && armed_q && all_met;
        if (!en)
            hit_vec = '0;
        else if (level_mode)
            hit_vec = fire_lvl ? sel : '0;
        else
            hit_vec = edge_hits;
    end

    always_ff @(posedge clk) begin
        if (rst || rearm)
            armed_q <= 1'b1;
        else if (fire_lvl)
            armed_q <= 1'b0;
        else if (sel_change)
            armed_q <= 1'b1;
    end

    // R9
    empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (m_high == '0 && m_low == '0) |-> hit_vec == '0);

    // R6
    level_no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (fire_lvl && !rearm) |=> !fire_lvl);

    // R4
    edge_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
    parameter int DIN_W  = 32,
    parameter int CH     = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIN_W-1:0]  din,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import cos_pkg::*;

    localparam int PAD_W = DATA_W - CH;

    ctrl_t         ctrl_q;
    logic [CH-1:0] m_high_q, m_low_q, stat_q;
    logic [CH-1:0] cur, prev, hit_vec;
    logic          stat_clr;
    logic          unused_bits;

    assign unused_bits = ^{din[DIN_W-1:CH], wr_data[DATA_W-1:CH]};

    cos_sync #(.W(CH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (din[CH-1:0]),
        .cur_o   (cur),
        .prev_o  (prev)
    );

    cos_trigger #(.CH(CH)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .en         (ctrl_q.en),
        .level_mode (ctrl_q.level_mode),
        .rearm      (wr_en),
        .m_high     (m_high_q),
        .m_low      (m_low_q),
        .cur        (cur),
        .prev       (prev),
        .hit_vec    (hit_vec)
    );

    assign stat_clr = rd_stb && (addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            m_high_q <= '0;
            m_low_q  <= '0;
            stat_q   <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    REG_CTRL: ctrl_q   <= ctrl_decode(wr_data);
                    REG_HIGH: m_high_q <= wr_data[CH-1:0];
                    REG_LOW:  m_low_q  <= wr_data[CH-1:0];
                    default:  ;
                endcase
            end
            stat_q <= (stat_clr ? '0 : stat_q) | hit_vec;
        end
    end

    always_comb begin
        case (addr)
            REG_CTRL: rd_data = ctrl_encode(ctrl_q);
            REG_HIGH: rd_data = {{PAD_W{1'b0}}, m_high_q};
            REG_LOW:  rd_data = {{PAD_W{1'b0}}, m_low_q};
            default:  rd_data = {{PAD_W{1'b0}}, stat_q};
        endcase
    end

    assign irq = |stat_q;

    // R3
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !stat_clr) |=> $stable(stat_q));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && hit_vec == '0) |=> stat_q == '0);

    // R8
    irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(hit_vec != '0));
endmodule

// File: tb/test_cos_irq_ctrl.sv
`timescale 1ns/1ps
module test_cos_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] din = '0;
    logic [1:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_stb = 1'b0;
    logic [31:0] rd_data;
    logic        irq;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    cos_irq_ctrl i_cos_irq_ctrl (
        .clk(clk), .rst(rst), .din(din), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic        lvl;
        logic [15:0] mh;
        logic [15:0] ml;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [15:0] exp_st;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h0001, 16'h0000, 32'h0000_0000, 32'h0000_0001, 16'h0001}, // R4 rise
        '{1'b0, 16'h0001, 16'h0000, 32'h0000_0001, 32'h0000_0000, 16'h0000}, // R4 fall unselected
        '{1'b0, 16'h0000, 16'h0010, 32'h0000_0010, 32'h0000_0000, 16'h0010}, // R4 fall
        '{1'b0, 16'h00F0, 16'h000F, 32'h0000_000F, 32'h0000_00F0, 16'h00FF}, // R4 mixed
        '{1'b0, 16'hFFFF, 16'h0000, 32'h0000_0000, 32'hFFFF_0000, 16'h0000}, // R2 upper lines
        '{1'b1, 16'h0003, 16'h0004, 32'h0000_0000, 32'h0000_0003, 16'h0007}, // R5 all met
        '{1'b1, 16'h0003, 16'h0000, 32'h0000_0000, 32'h0000_0001, 16'h0000}, // R5 partly met
        '{1'b0, 16'h0000, 16'h0000, 32'h0000_0000, 32'h0000_FFFF, 16'h0000}  // R9 empty masks
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic clr, output logic [31:0] v);
        addr = a; rd_stb = clr;
        #1 v = rd_data;
        tick(1);
        rd_stb = 1'b0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        tick(3);
        rst = 1'b0;
        tick(1);

        // R10 reset state
        chk("R10 irq", {31'b0, irq}, 32'h0);
        rd(2'd0, 1'b0, v); chk("R10 ctrl", v, 32'h0);
        rd(2'd3, 1'b0, v); chk("R10 status", v, 32'h0);

        // R3 / R2 register readback
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 1'b0, v); chk("R3 ctrl readback", v, 32'h0000_0006);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, 1'b0, v); chk("R2 mask width", v, 32'h0000_FFFF);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd0, 32'h0);
            wr(2'd1, {16'h0, VECS[i].mh});
            wr(2'd2, {16'h0, VECS[i].ml});
            din = VECS[i].d0;
            tick(4);
            wr(2'd0, VECS[i].lvl ? 32'h6 : 32'h4);
            tick(2);
            rd(2'd3, 1'b1, v);
            tick(1);
            din = VECS[i].d1;
            tick(3);
            chk($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, VECS[i].exp_st != 16'h0});
            rd(2'd3, 1'b1, v);
            chk($sformatf("R4/R5 vec%0d status", i), v, {16'h0, VECS[i].exp_st});
        end

        // R1 latency and R7 clear-on-read
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h1); wr(2'd2, 32'h0);
        din = 32'h0; tick(4);
        wr(2'd0, 32'h4);
        din = 32'h1;
        tick(2);
        chk("R1 not before third edge", {31'b0, irq}, 32'h0);
        tick(1);
        chk("R1 at third edge", {31'b0, irq}, 32'h1);
        rd(2'd3, 1'b1, v);
        chk("R7 read value", v, 32'h1);
        chk("R7 irq after clear", {31'b0, irq}, 32'h0);
        rd(2'd3, 1'b0, v);
        chk("R7 status empty", v, 32'h0);

        // R3 disabled
        wr(2'd0, 32'h0);
        din = 32'h0; tick(4);
        din = 32'h1; tick(4);
        chk("R3 disabled no irq", {31'b0, irq}, 32'h0);

        // R6 level re-arm
        din = 32'h0; tick(4);
        wr(2'd0, 32'h6);
        din = 32'h1; tick(3);
        chk("R6 first level fire", {31'b0, irq}, 32'h1);
        rd(2'd3, 1'b1, v);
        tick(5);
        chk("R6 no refire while held", {31'b0, irq}, 32'h0);
        din = 32'h21; tick(4);
        chk("R6 unselected toggle up", {31'b0, irq}, 32'h0);
        din = 32'h01; tick(4);
        chk("R6 unselected toggle down", {31'b0, irq}, 32'h0);
        din = 32'h00; tick(4);
        chk("R6 rearmed not met", {31'b0, irq}, 32'h0);
        din = 32'h01; tick(3);
        chk("R6 refire after change", {31'b0, irq}, 32'h1);
        rd(2'd3, 1'b1, v);
        chk("R6 refire status", v, 32'h1);
        tick(3);
        wr(2'd0, 32'h6);
        tick(1);
        chk("R6 write rearms", {31'b0, irq}, 32'h1);
        rd(2'd3, 1'b1, v);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule